// File: doc/BRIEF.md
# Address Monitor Sleep Controller

This block sits beside one processor core. It lets software set a watch on one cache line of physical memory and then put the core into a low-power wait. An arm request records a physical address. The watched region is the 64 bytes that start at that address. The block then compares each snooped store against that region using byte ranges. A store that overlaps the region clears the watch. If the core is waiting, the same store wakes it.

A wait request parks the core in one of two wait states. If nothing is armed when the request arrives, the request completes at once and the core stays active. Bits of the extension operand select two options: a wait that an interrupt ends even while interrupts are masked, and a timed wait that loads an external timer as the core goes to sleep.

Requests with the wrong privilege level or with reserved extension bits return a one-cycle fault pulse with an encoded cause. Fault, state, armed and timer outputs are all registered, so each shows its result one clock after the request.

Top module: `addr_watch_sleep`

## Requirements
- R1: An arm or wait request with a privilege level other than 0 gives fault code 1 (undefined opcode) one cycle later. It does not arm the monitor and does not enter a wait state.
- R2: An arm request at privilege 0 with a nonzero extension operand gives fault code 2 (general protection) and does not arm the monitor.
- R3: A valid arm request arms the monitor only when the write-back attribute input is high. Otherwise it changes nothing and raises no fault. After reset the monitor is disarmed, the state is active and no fault is pending.
- R4: A snooped store of address S and length L hits when L is nonzero, S <= A+63 and S+L > A, where A is the armed address. A hit clears the armed flag.
- R5: A hit while the core is in either wait state returns the state to active (code 0).
- R6: A plain wait accepts only extension bit 0. A timed wait accepts bits 0 and 1. Any other set bit gives fault code 2, and the core does not sleep.
- R7: A legal wait request with the monitor unarmed completes at once. The state stays active and no fault is raised.
- R8: A legal wait with the monitor armed enters state 2 when extension bit 0 is set, or state 1 otherwise. In state 1 an interrupt wakes the core only if the interrupt-enable flag is set. In state 2 an interrupt always wakes it.
- R9: A timed wait with extension bit 1 set pulses the timer load output for one cycle, carrying the 32-bit timer value, in the same cycle the state changes to a wait state. Timer expiry wakes only a wait entered this way.
- R10: While the no-op configuration input is high, a legal wait request leaves the state active and the armed flag unchanged.
- R11: NMI, SMI, INIT or reset events wake the core from either wait state to active and clear the armed flag.
- R12: Arm and wait requests that arrive while the core is in a wait state are ignored and raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_req | input | 1 | Arm request strobe |
| arm_addr | input | 48 | Physical start address of the watched line |
| arm_cpl | input | 2 | Privilege level of the arm request |
| arm_ext | input | 32 | Extension operand of the arm request |
| arm_wb | input | 1 | Target memory type is write-back |
| wait_req | input | 1 | Wait request strobe |
| wait_cpl | input | 2 | Privilege level of the wait request |
| wait_timed | input | 1 | Wait variant: 1 timed, 0 plain |
| wait_ext | input | 32 | Extension operand of the wait request |
| wait_timer | input | 32 | Timer value for a timed wait |
| st_valid | input | 1 | Snooped store valid |
| st_addr | input | 48 | Snooped store start address |
| st_len | input | 8 | Snooped store length in bytes |
| ev_intr | input | 1 | Maskable interrupt pending |
| ev_nmi | input | 1 | NMI event |
| ev_smi | input | 1 | SMI event |
| ev_init | input | 1 | INIT event |
| ev_reset | input | 1 | Reset event |
| if_flag | input | 1 | Interrupt-enable flag |
| timer_expire | input | 1 | Wait timer expired |
| wait_nop_cfg | input | 1 | Treat every wait request as a no-op |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | Fault cause: 0 none, 1 undefined opcode, 2 general protection |
| act_state | output | 2 | Activity: 0 active, 1 wait, 2 wait woken by any interrupt |
| timer_load | output | 1 | Timer load strobe |
| timer_value | output | 32 | Value to load into the timer |
| armed | output | 1 | Monitor armed |

## Verification
An error in the stored line base, or in the overlap compare, shows up on the armed output in the cycle after the store. A store that should miss clears the flag, or one that should hit leaves it set. The bench therefore sweeps store offsets and lengths across both ends of the line. A wrong wait state stays hidden until the next interrupt arrives: the core then wakes when it should not, or stays asleep. For that reason every wake source is applied in each state that it could reach.

// File: rtl/aws_pkg.sv
package aws_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WAIT    = 2'd1,
    ST_WAIT_AI = 2'd2
  } act_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } flt_t;
endpackage

// File: rtl/aws_overlap.sv
module aws_overlap #(
  parameter int PA_W       = 48,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 8
) (
  input  logic [PA_W-1:0]  base,
  input  logic [PA_W-1:0]  st_addr,
  input  logic [LEN_W-1:0] st_len,
  output logic             hit
);
  localparam int SUM_W = PA_W + 1;

  logic [SUM_W-1:0] line_last;
  logic [SUM_W-1:0] st_first;
  logic [SUM_W-1:0] st_past;

  always_comb begin
    line_last = {1'b0, base} + SUM_W'(LINE_BYTES - 1);
    st_first  = {1'b0, st_addr};
    st_past   = st_first + SUM_W'(st_len);
    hit       = (st_len != '0) && (st_first <= line_last) && (st_past > {1'b0, base});
  end
endmodule

// File: rtl/aws_req_check.sv
module aws_req_check
  import aws_pkg::*;
#(
  parameter int EXT_W = 32
) (
  input  logic [1:0]       arm_cpl,
  input  logic [EXT_W-1:0] arm_ext,
  input  logic [1:0]       wait_cpl,
  input  logic             wait_timed,
  input  logic [EXT_W-1:0] wait_ext,
  output flt_t             arm_flt,
  output flt_t             wait_flt
);
  logic [EXT_W-1:0] legal_mask;

  always_comb begin
    legal_mask = wait_timed ? EXT_W'(3) : EXT_W'(1);

    if (arm_cpl != 2'd0)       arm_flt = FLT_UD;
    else if (arm_ext != '0)    arm_flt = FLT_GP;
    else                       arm_flt = FLT_NONE;

    if (wait_cpl != 2'd0)                      wait_flt = FLT_UD;
    else if ((wait_ext & ~legal_mask) != '0)   wait_flt = FLT_GP;
    else                                       wait_flt = FLT_NONE;
  end
endmodule

// File: rtl/addr_watch_sleep.sv
module addr_watch_sleep
  import aws_pkg::*;
#(
  parameter int PA_W       = 48,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 8,
  parameter int EXT_W      = 32,
  parameter int TMR_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_req,
  input  logic [PA_W-1:0]  arm_addr,
  input  logic [1:0]       arm_cpl,
  input  logic [EXT_W-1:0] arm_ext,
  input  logic             arm_wb,
  input  logic             wait_req,
  input  logic [1:0]       wait_cpl,
  input  logic             wait_timed,
  input  logic [EXT_W-1:0] wait_ext,
  input  logic [TMR_W-1:0] wait_timer,
  input  logic             st_valid,
  input  logic [PA_W-1:0]  st_addr,
  input  logic [LEN_W-1:0] st_len,
  input  logic             ev_intr,
  input  logic             ev_nmi,
  input  logic             ev_smi,
  input  logic             ev_init,
  input  logic             ev_reset,
  input  logic             if_flag,
  input  logic             timer_expire,
  input  logic             wait_nop_cfg,
  output logic             fault_valid,
  output logic [1:0]       fault_code,
  output logic [1:0]       act_state,
  output logic             timer_load,
  output logic [TMR_W-1:0] timer_value,
  output logic             armed
);
  // registered state
  logic             armed_q, armed_d;
  logic [PA_W-1:0]  base_q;
  logic             base_en;
  act_t             state_q, state_d;
  logic             timed_q, timed_d;
  flt_t             flt_q, flt_d;
  logic             tload_q, tload_d;
  logic [TMR_W-1:0] tval_q;
  logic             tval_en;

  flt_t arm_flt, wait_flt;
  logic range_hit, store_hit, asleep, wake_evt, arm_go, wait_go;

  aws_overlap #(.PA_W(PA_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)) u_ovl (
    .base    (base_q),
    .st_addr (st_addr),
    .st_len  (st_len),
    .hit     (range_hit)
  );

  aws_req_check #(.EXT_W(EXT_W)) u_chk_req (
    .arm_cpl    (arm_cpl),
    .arm_ext    (arm_ext),
    .wait_cpl   (wait_cpl),
    .wait_timed (wait_timed),
    .wait_ext   (wait_ext),
    .arm_flt    (arm_flt),
    .wait_flt   (wait_flt)
  );

  always_comb begin
    store_hit = st_valid && armed_q && range_hit;
    asleep    = (state_q != ST_ACTIVE);
    wake_evt  = asleep && (ev_nmi || ev_smi || ev_init || ev_reset ||
                           (timer_expire && timed_q) ||
                           (ev_intr && (if_flag || state_q == ST_WAIT_AI)));
    arm_go    = arm_req && !asleep;
    wait_go   = wait_req && !asleep && !arm_req;

    armed_d = armed_q;
    base_en = 1'b0;
    state_d = state_q;
    timed_d = timed_q;
    flt_d   = FLT_NONE;
    tload_d = 1'b0;
    tval_en = 1'b0;

    if (store_hit || wake_evt) armed_d = 1'b0;
    if (asleep && (store_hit || wake_evt)) begin
      state_d = ST_ACTIVE;
      timed_d = 1'b0;
    end

    if (arm_go) begin
      if (arm_flt != FLT_NONE) begin
        flt_d = arm_flt;
      end else if (arm_wb) begin
        armed_d = 1'b1;
        base_en = 1'b1;
      end
    end

    if (wait_go) begin
      if (wait_flt != FLT_NONE) begin
        flt_d = wait_flt;
      end else if (!wait_nop_cfg && armed_q && !store_hit) begin
        state_d = wait_ext[0] ? ST_WAIT_AI : ST_WAIT;
        if (wait_timed && wait_ext[1]) begin
          timed_d = 1'b1;
          tload_d = 1'b1;
          tval_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      state_q <= ST_ACTIVE;
      timed_q <= 1'b0;
      flt_q   <= FLT_NONE;
      tload_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      state_q <= state_d;
      timed_q <= timed_d;
      flt_q   <= flt_d;
      tload_q <= tload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      tval_q <= '0;
    end else begin
      if (base_en) base_q <= arm_addr;
      if (tval_en) tval_q <= wait_timer;
    end
  end

  assign armed       = armed_q;
  assign act_state   = state_q;
  assign fault_valid = (flt_q != FLT_NONE);
  assign fault_code  = flt_q;
  assign timer_load  = tload_q;
  assign timer_value = tval_q;
endmodule

// File: rtl/addr_watch_sleep_chk.sv
module addr_watch_sleep_chk #(
  parameter int EXT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_req,
  input logic [1:0]       arm_cpl,
  input logic [EXT_W-1:0] arm_ext,
  input logic             arm_wb,
  input logic             wait_req,
  input logic             fault_valid,
  input logic [1:0]       fault_code,
  input logic [1:0]       act_state,
  input logic             timer_load,
  input logic             armed
);
  AST_UD_ARM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && act_state == 2'd0 && arm_cpl != 2'd0 && !armed) |=> (!armed && fault_valid && fault_code == 2'd1)); // R1
  AST_GP_ARM_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && act_state == 2'd0 && arm_cpl == 2'd0 && arm_ext != '0) |=> (fault_valid && fault_code == 2'd2)); // R2
  AST_NON_WB_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && act_state == 2'd0 && arm_cpl == 2'd0 && arm_ext == '0 && !arm_wb && !armed) |=> (!armed && !fault_valid)); // R3
  AST_UNARMED_WAIT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !arm_req && act_state == 2'd0 && !armed) |=> (act_state == 2'd0)); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    act_state != 2'd3); // R8
  AST_TLOAD_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    timer_load |-> (act_state != 2'd0)); // R9
  AST_SLEEP_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (act_state != 2'd0 && (arm_req || wait_req)) |=> !fault_valid); // R12
endmodule

bind addr_watch_sleep addr_watch_sleep_chk #(.EXT_W(EXT_W)) u_aws_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_req     (arm_req),
  .arm_cpl     (arm_cpl),
  .arm_ext     (arm_ext),
  .arm_wb      (arm_wb),
  .wait_req    (wait_req),
  .fault_valid (fault_valid),
  .fault_code  (fault_code),
  .act_state   (act_state),
  .timer_load  (timer_load),
  .armed       (armed)
);

// File: tb/addr_watch_sleep_test.sv
`timescale 1ns/1ps
module addr_watch_sleep_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_req = 1'b0;
  logic [47:0] arm_addr = '0;
  logic [1:0]  arm_cpl = '0;
  logic [31:0] arm_ext = '0;
  logic        arm_wb = 1'b0;
  logic        wait_req = 1'b0;
  logic [1:0]  wait_cpl = '0;
  logic        wait_timed = 1'b0;
  logic [31:0] wait_ext = '0;
  logic [31:0] wait_timer = '0;
  logic        st_valid = 1'b0;
  logic [47:0] st_addr = '0;
  logic [7:0]  st_len = '0;
  logic        ev_intr = 1'b0, ev_nmi = 1'b0, ev_smi = 1'b0, ev_init = 1'b0, ev_reset = 1'b0;
  logic        if_flag = 1'b0, timer_expire = 1'b0, wait_nop_cfg = 1'b0;
  logic        fault_valid;
  logic [1:0]  fault_code;
  logic [1:0]  act_state;
  logic        timer_load;
  logic [31:0] timer_value;
  logic        armed;

  int total = 0;
  int bad = 0;
  localparam logic [47:0] BASE = 48'h00AB_CDEF_1035;

  always #10 clk = ~clk;

  addr_watch_sleep uut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_arm(input logic [47:0] a, input logic [1:0] cpl, input logic [31:0] ext, input logic wb);
    arm_req = 1'b1; arm_addr = a; arm_cpl = cpl; arm_ext = ext; arm_wb = wb;
    tick();
    arm_req = 1'b0; arm_cpl = '0; arm_ext = '0; arm_wb = 1'b0;
  endtask

  task automatic do_wait(input logic timed, input logic [1:0] cpl, input logic [31:0] ext, input logic [31:0] tmr);
    wait_req = 1'b1; wait_timed = timed; wait_cpl = cpl; wait_ext = ext; wait_timer = tmr;
    tick();
    wait_req = 1'b0; wait_timed = 1'b0; wait_cpl = '0; wait_ext = '0;
  endtask

  task automatic do_store(input logic [47:0] a, input logic [7:0] len);
    st_valid = 1'b1; st_addr = a; st_len = len;
    tick();
    st_valid = 1'b0; st_len = '0;
  endtask

  task automatic do_evt(input int which);
    case (which)
      0: ev_nmi = 1'b1;
      1: ev_smi = 1'b1;
      2: ev_init = 1'b1;
      3: ev_reset = 1'b1;
      4: ev_intr = 1'b1;
      default: timer_expire = 1'b1;
    endcase
    tick();
    ev_nmi = 1'b0; ev_smi = 1'b0; ev_init = 1'b0; ev_reset = 1'b0; ev_intr = 1'b0; timer_expire = 1'b0;
  endtask

  task automatic clear_all();
    do_evt(0);
    do_store(BASE, 8'd64);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R3 reset state
    chk("R3 reset armed", armed, 0);
    chk("R3 reset state", act_state, 0);
    chk("R3 reset fault", fault_valid, 0);
    chk("R9 reset tload", timer_load, 0);

    // R1 privilege faults
    for (int c = 1; c < 4; c++) begin
      do_arm(BASE, 2'(c), 0, 1'b1);
      chk("R1 arm fault code", fault_code, 1);
      chk("R1 arm fault valid", fault_valid, 1);
      chk("R1 arm not armed", armed, 0);
    end
    do_arm(BASE, 0, 0, 1'b1);
    chk("R3 armed wb", armed, 1);
    chk("R3 no fault", fault_valid, 0);
    do_wait(1'b0, 2'd2, 0, 0);
    chk("R1 wait fault", fault_code, 1);
    chk("R1 wait no sleep", act_state, 0);
    tick();
    chk("R1 fault one cycle", fault_valid, 0);
    clear_all();

    // R2 arm extension
    do_arm(BASE, 0, 32'h1, 1'b1);
    chk("R2 gp code", fault_code, 2);
    chk("R2 not armed", armed, 0);
    do_arm(BASE, 0, 32'h8000_0000, 1'b1);
    chk("R2 gp code msb", fault_code, 2);
    chk("R2 not armed msb", armed, 0);

    // R3 non write-back
    do_arm(BASE, 0, 0, 1'b0);
    chk("R3 non-wb not armed", armed, 0);
    chk("R3 non-wb no fault", fault_valid, 0);

    // R4 overlap sweep
    for (int off = -70; off <= 70; off++) begin
      for (int li = 0; li < 7; li++) begin
        int len;
        logic exp_hit;
        case (li)
          0: len = 0; 1: len = 1; 2: len = 2; 3: len = 5;
          4: len = 8; 5: len = 64; default: len = 65;
        endcase
        do_arm(BASE, 0, 0, 1'b1);
        do_store(48'(longint'(BASE) + off), 8'(len));
        exp_hit = (len != 0) && (off <= 63) && (off + len > 0);
        chk("R4 overlap armed", armed, !exp_hit);
      end
    end
    clear_all();

    // R5 hit wakes both states; R8 encodings
    do_arm(BASE, 0, 0, 1'b1);
    do_wait(1'b0, 0, 0, 0);
    chk("R8 plain state 1", act_state, 1);
    chk("R5 armed during wait", armed, 1);
    do_store(BASE + 48'd63, 8'd1);
    chk("R5 hit wakes state1", act_state, 0);
    chk("R4 hit clears", armed, 0);
    do_arm(BASE, 0, 0, 1'b1);
    do_wait(1'b0, 0, 32'h1, 0);
    chk("R8 bit0 state 2", act_state, 2);
    do_store(BASE - 48'd3, 8'd4);
    chk("R5 hit wakes state2", act_state, 0);

    // R6 extension legality
    do_arm(BASE, 0, 0, 1'b1);
    do_wait(1'b0, 0, 32'h2, 0);
    chk("R6 plain bit1 gp", fault_code, 2);
    chk("R6 plain bit1 no sleep", act_state, 0);
    do_wait(1'b1, 0, 32'h4, 0);
    chk("R6 timed bit2 gp", fault_code, 2);
    chk("R6 timed bit2 no sleep", act_state, 0);
    do_wait(1'b1, 0, 32'h3, 32'h1234_5678);
    chk("R6 timed bit0|1 legal", fault_valid, 0);
    chk("R6 timed bit0|1 state", act_state, 2);
    chk("R9 load with state", timer_load, 1);
    chk("R9 load value", timer_value, 32'h1234_5678);
    tick();
    chk("R9 load one cycle", timer_load, 0);
    do_evt(5);
    chk("R9 expiry wakes timed", act_state, 0);
    chk("R9 expiry disarms", armed, 0);

    // R7 unarmed wait
    do_wait(1'b0, 0, 0, 0);
    chk("R7 unarmed stays active", act_state, 0);
    chk("R7 unarmed no fault", fault_valid, 0);

    // R8 interrupt masking
    do_arm(BASE, 0, 0, 1'b1);
    do_wait(1'b0, 0, 0, 0);
    if_flag = 1'b0;
    do_evt(4);
    chk("R8 masked intr keeps state1", act_state, 1);
    if_flag = 1'b1;
    do_evt(4);
    chk("R8 unmasked intr wakes", act_state, 0);
    chk("R8 wake disarms", armed, 0);
    if_flag = 1'b0;
    do_arm(BASE, 0, 0, 1'b1);
    do_wait(1'b0, 0, 32'h1, 0);
    do_evt(4);
    chk("R8 masked intr wakes state2", act_state, 0);

    // R9 timed without bit1, expiry ignored
    do_arm(BASE, 0, 0, 1'b1);
    do_wait(1'b1, 0, 32'h0, 32'hDEAD_BEEF);
    chk("R9 no bit1 no load", timer_load, 0);
    chk("R9 no bit1 state1", act_state, 1);
    do_evt(5);
    chk("R9 expiry ignored untimed", act_state, 1);

    // R12 requests ignored while asleep
    do_arm(BASE + 48'd4096, 2'd3, 0, 1'b1);
    chk("R12 arm ignored no fault", fault_valid, 0);
    do_wait(1'b0, 2'd1, 0, 0);
    chk("R12 wait ignored no fault", fault_valid, 0);
    chk("R12 still asleep", act_state, 1);
    do_store(BASE + 48'd10, 8'd1);
    chk("R12 old line still watched", act_state, 0);

    // R11 other wake events from both states
    for (int e = 0; e < 4; e++) begin
      for (int s = 0; s < 2; s++) begin
        do_arm(BASE, 0, 0, 1'b1);
        do_wait(1'b0, 0, 32'(s), 0);
        chk("R11 entered wait", act_state, s + 1);
        do_evt(e);
        chk("R11 event wakes", act_state, 0);
        chk("R11 event disarms", armed, 0);
      end
    end

    // R10 no-op configuration
    wait_nop_cfg = 1'b1;
    do_arm(BASE, 0, 0, 1'b1);
    do_wait(1'b1, 0, 32'h3, 32'h55);
    chk("R10 nop stays active", act_state, 0);
    chk("R10 nop keeps armed", armed, 1);
    chk("R10 nop no load", timer_load, 0);
    wait_nop_cfg = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule